// File: doc/BRIEF.md
# Rotate, Shift and Single-Bit Operand Unit

This block takes one 8-bit operand and applies a byte-level bit manipulation to it. The manipulations are circular rotates, rotates through the carry flag, arithmetic and logical shifts, and a nibble exchange. It can also test, force high or force low a single bit chosen by a 3-bit index. Next to the new operand value it returns the four condition flags zero (z), subtract (n), half-carry (h) and carry (c). Each flag comes with its own load enable, so the flags register keeps any flag the operation does not touch. A separate enable says whether the operand destination should be written.

A decoder sits in the processor's execute stage and presents the operation code, the operand, the bit index, the current carry and a marker for the short accumulator-only rotate forms. Results are registered, and they appear on the outputs one clock after the inputs are sampled. A new operation can be issued every cycle. Prefix decoding and memory read-modify-write sequencing belong to the surrounding core.

Top module: `rsb_unit`

## Requirements
- R1: After reset, and for operation codes 0 and 12 to 15, `resultWe` is 0, `flagsWe` is 0000, `flagsOut` is 0000 and `result` is 0.
- R2: Code 1 rotates left and code 2 rotates right. The bit that leaves the byte lands both in the carry flag and at the opposite end of the result.
- R3: Code 3 rotates left through carry and code 4 rotates right through carry. The incoming carry fills the vacated bit and the bit that leaves goes to the carry flag.
- R4: Code 5 shifts left and fills bit 0 with 0. Code 6 shifts right and keeps bit 7. Code 7 shifts right and fills bit 7 with 0. In all three the bit that leaves goes to the carry flag.
- R5: For codes 1 to 7 with `accShort` low, z is 1 exactly when the result is zero, n and h are 0, `flagsWe` is 1111 and `resultWe` is 1.
- R6: With `accShort` high, codes 1 to 4 give z=0, n=0, h=0, with c set to the bit that leaves. For every other code `accShort` has no effect.
- R7: Code 8 exchanges the upper and lower nibbles, writes z from the result, clears n, h and c, and sets `flagsWe` to 1111.
- R8: Code 9 tests operand bit `bitIdx`, where index 0 is the least significant bit. z is 1 when that bit is 0, n is 0 and h is 1. `flagsWe` is 1110, so carry is not loaded, and `resultWe` is 0.
- R9: Code 10 forces bit `bitIdx` to 1 and code 11 forces it to 0. All other bits pass through, `resultWe` is 1 and `flagsWe` is 0000.
- R10: Outputs reflect the inputs sampled at the previous rising clock edge. Bits 3..0 of `flagsOut` and `flagsWe` are z, n, h, c, and a flag whose enable is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| operand | input | 8 | Operand value |
| bitIdx | input | 3 | Bit selector for test/set/reset |
| carryIn | input | 1 | Current carry flag |
| opSel | input | 4 | Operation code |
| accShort | input | 1 | Marks the short accumulator-only rotate forms |
| result | output | 8 | New operand value |
| resultWe | output | 1 | Operand destination write enable |
| flagsOut | output | 4 | New z, n, h, c flag values |
| flagsWe | output | 4 | Per-flag load enables for z, n, h, c |

## Verification
Every result, flag value and enable is due exactly one rising edge after its inputs are presented, with no dependence on earlier operations. The driver applies each operation on a falling edge and queues the expected outputs. The monitor pops one item two time units after each following rising edge, so the comparison lands in the cycle the output register has just loaded. Because operations go in back to back, a latency of zero or two cycles shows up as a mismatch against the neighbouring item.

// File: rtl/rsb_pkg.sv
package rsb_pkg;

  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_H = 1;
  localparam int FLAG_C = 0;
  localparam int FLAG_CNT = 4;

  typedef enum logic [3:0] {
    K_NONE = 4'd0,
    K_ROTL = 4'd1,
    K_ROTR = 4'd2,
    K_RCL  = 4'd3,
    K_RCR  = 4'd4,
    K_SLA  = 4'd5,
    K_SRA  = 4'd6,
    K_SRL  = 4'd7,
    K_SWAP = 4'd8,
    K_BIT  = 4'd9,
    K_SET  = 4'd10,
    K_RES  = 4'd11
  } kind_e;

  typedef struct packed {
    kind_e                kind;
    logic                 writeRes;
    logic [FLAG_CNT-1:0]  flagWe;
    logic                 zClear;
  } strobe_t;

endpackage

// File: rtl/rsb_ctrl.sv
module rsb_ctrl
  import rsb_pkg::*;
(
  input  logic [3:0] opSel,
  input  logic       accShort,
  output strobe_t    stb
);

  always_comb begin
    stb = '{kind: K_NONE, writeRes: 1'b0, flagWe: 4'b0000, zClear: 1'b0};
    case (opSel)
      4'd1, 4'd2, 4'd3, 4'd4: begin
        stb.kind     = kind_e'(opSel);
        stb.writeRes = 1'b1;
        stb.flagWe   = 4'b1111;
        stb.zClear   = accShort;
      end
      4'd5, 4'd6, 4'd7, 4'd8: begin
        stb.kind     = kind_e'(opSel);
        stb.writeRes = 1'b1;
        stb.flagWe   = 4'b1111;
      end
      4'd9: begin
        stb.kind   = K_BIT;
        stb.flagWe = 4'b1110;
      end
      4'd10, 4'd11: begin
        stb.kind     = kind_e'(opSel);
        stb.writeRes = 1'b1;
      end
      default: ;
    endcase
  end

  // R1: codes outside the defined set must produce no write strobes
  always_comb begin
    if (opSel == 4'd0 || opSel > 4'd11)
      a_r1_idle_strobes : assert (!stb.writeRes && stb.flagWe == 4'b0000 && !stb.zClear);
  end

endmodule

// File: rtl/rsb_datapath.sv
module rsb_datapath
  import rsb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W),
  localparam int HALF_W = DATA_W / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobe_t             stb,
  input  logic [DATA_W-1:0]   operand,
  input  logic [IDX_W-1:0]    bitIdx,
  input  logic                carryIn,
  output logic [DATA_W-1:0]   result,
  output logic                resultWe,
  output logic [FLAG_CNT-1:0] flagsOut,
  output logic [FLAG_CNT-1:0] flagsWe
);

  logic [DATA_W-1:0]   nextRes;
  logic [DATA_W-1:0]   selMask;
  logic                outBit;
  logic                zVal;
  logic [FLAG_CNT-1:0] flagVal;
  logic                topBit;
  logic                lowBit;

  assign topBit  = operand[DATA_W-1];
  assign lowBit  = operand[0];
  assign selMask = {{(DATA_W-1){1'b0}}, 1'b1} << bitIdx;

  always_comb begin
    nextRes = operand;
    outBit  = 1'b0;
    case (stb.kind)
      K_ROTL: begin nextRes = {operand[DATA_W-2:0], topBit};  outBit = topBit; end
      K_ROTR: begin nextRes = {lowBit, operand[DATA_W-1:1]};  outBit = lowBit; end
      K_RCL:  begin nextRes = {operand[DATA_W-2:0], carryIn}; outBit = topBit; end
      K_RCR:  begin nextRes = {carryIn, operand[DATA_W-1:1]}; outBit = lowBit; end
      K_SLA:  begin nextRes = {operand[DATA_W-2:0], 1'b0};    outBit = topBit; end
      K_SRA:  begin nextRes = {topBit, operand[DATA_W-1:1]};  outBit = lowBit; end
      K_SRL:  begin nextRes = {1'b0, operand[DATA_W-1:1]};    outBit = lowBit; end
      K_SWAP: nextRes = {operand[HALF_W-1:0], operand[DATA_W-1:HALF_W]};
      K_SET:  nextRes = operand | selMask;
      K_RES:  nextRes = operand & ~selMask;
      default: ;
    endcase
  end

  always_comb begin
    if (stb.zClear)
      zVal = 1'b0;
    else if (stb.kind == K_BIT)
      zVal = ~|(operand & selMask);
    else
      zVal = ~|nextRes;
    flagVal = '0;
    flagVal[FLAG_Z] = zVal;
    flagVal[FLAG_N] = 1'b0;
    flagVal[FLAG_H] = (stb.kind == K_BIT);
    flagVal[FLAG_C] = outBit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result   <= '0;
      resultWe <= 1'b0;
      flagsOut <= '0;
      flagsWe  <= '0;
    end else begin
      result   <= stb.writeRes ? nextRes : '0;
      resultWe <= stb.writeRes;
      flagsOut <= flagVal & stb.flagWe;
      flagsWe  <= stb.flagWe;
    end
  end

  // R2: circular left rotate sends the old top bit to carry and bit 0
  a_r2_rotl_wrap : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stb.kind) == K_ROTL) |->
      (flagsOut[FLAG_C] == $past(topBit) && result[0] == $past(topBit)));

  // R4: arithmetic right shift keeps the sign bit
  a_r4_sra_sign : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stb.kind) == K_SRA) |->
      (result[DATA_W-1] == $past(topBit) && flagsOut[FLAG_C] == $past(lowBit)));

  // R6: short accumulator forms never report zero
  a_r6_short_zero : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stb.zClear)) |-> !flagsOut[FLAG_Z]);

  // R8: bit test loads flags only, with half-carry set and carry untouched
  a_r8_bit_flags : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(stb.kind) == K_BIT) |->
      (!resultWe && flagsWe == 4'b1110 && flagsOut[FLAG_H] &&
       flagsOut[FLAG_Z] == !$past(operand[bitIdx])));

  // R9: set and reset never load flags
  a_r9_setres_noflags : assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ($past(stb.kind) == K_SET || $past(stb.kind) == K_RES)) |->
      (resultWe && flagsWe == 4'b0000));

  // R10: a flag without its load enable reads zero
  a_r10_masked_zero : assert property (@(posedge clk) disable iff (!rst_n)
    (flagsOut & ~flagsWe) == 4'b0000);

endmodule

// File: rtl/rsb_unit.sv
module rsb_unit
  import rsb_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int IDX_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] operand,
  input  logic [IDX_W-1:0]  bitIdx,
  input  logic              carryIn,
  input  logic [3:0]        opSel,
  input  logic              accShort,
  output logic [DATA_W-1:0] result,
  output logic              resultWe,
  output logic [3:0]        flagsOut,
  output logic [3:0]        flagsWe
);

  strobe_t stb;

  rsb_ctrl u_ctrl (
    .opSel    (opSel),
    .accShort (accShort),
    .stb      (stb)
  );

  rsb_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .operand  (operand),
    .bitIdx   (bitIdx),
    .carryIn  (carryIn),
    .result   (result),
    .resultWe (resultWe),
    .flagsOut (flagsOut),
    .flagsWe  (flagsWe)
  );

endmodule

// File: tb/rsb_unit_bench.sv
module rsb_unit_bench;

  typedef struct {
    logic [7:0] res;
    logic       we;
    logic [3:0] fl;
    logic [3:0] fwe;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] operand = '0;
  logic [2:0] bitIdx = '0;
  logic       carryIn = 1'b0;
  logic [3:0] opSel = '0;
  logic       accShort = 1'b0;
  logic [7:0] result;
  logic       resultWe;
  logic [3:0] flagsOut;
  logic [3:0] flagsWe;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  item_t sbq[$];

  always #5 clk = ~clk;

  rsb_unit u_rsb_unit (
    .clk(clk), .rst_n(rst_n), .operand(operand), .bitIdx(bitIdx),
    .carryIn(carryIn), .opSel(opSel), .accShort(accShort),
    .result(result), .resultWe(resultWe), .flagsOut(flagsOut), .flagsWe(flagsWe)
  );

  function automatic item_t model(input logic [3:0] op, input logic [7:0] a,
                                  input logic [2:0] idx, input logic cy,
                                  input logic sh, input string tag);
    item_t e;
    logic [7:0] r;
    logic c;
    e.tag = tag; e.res = 8'h00; e.we = 1'b0; e.fl = 4'b0000; e.fwe = 4'b0000;
    r = a; c = 1'b0;
    if (op >= 4'd1 && op <= 4'd8) begin
      case (op)
        4'd1: begin r = {a[6:0], a[7]}; c = a[7]; end
        4'd2: begin r = {a[0], a[7:1]}; c = a[0]; end
        4'd3: begin r = {a[6:0], cy};   c = a[7]; end
        4'd4: begin r = {cy, a[7:1]};   c = a[0]; end
        4'd5: begin r = {a[6:0], 1'b0}; c = a[7]; end
        4'd6: begin r = {a[7], a[7:1]}; c = a[0]; end
        4'd7: begin r = {1'b0, a[7:1]}; c = a[0]; end
        default: begin r = {a[3:0], a[7:4]}; c = 1'b0; end
      endcase
      e.res = r; e.we = 1'b1; e.fwe = 4'b1111;
      e.fl = {(sh && op <= 4'd4) ? 1'b0 : (r == 8'h00), 1'b0, 1'b0, c};
    end else if (op == 4'd9) begin
      e.fwe = 4'b1110;
      e.fl = {~a[idx], 1'b0, 1'b1, 1'b0};
    end else if (op == 4'd10 || op == 4'd11) begin
      r = a; r[idx] = (op == 4'd10);
      e.res = r; e.we = 1'b1;
    end
    return e;
  endfunction

  task automatic drive(input logic [3:0] op, input logic [7:0] a,
                       input logic [2:0] idx, input logic cy,
                       input logic sh, input string tag);
    @(negedge clk);
    opSel = op; operand = a; bitIdx = idx; carryIn = cy; accShort = sh;
    sbq.push_back(model(op, a, idx, cy, sh, tag));
  endtask

  task automatic compare(input item_t e);
    checks++;
    if (result !== e.res || resultWe !== e.we || flagsOut !== e.fl || flagsWe !== e.fwe) begin
      fails++;
      $display("FAIL %s: got res=%h we=%b fl=%b fwe=%b, expected res=%h we=%b fl=%b fwe=%b",
               e.tag, result, resultWe, flagsOut, flagsWe, e.res, e.we, e.fl, e.fwe);
    end
  endtask

  // monitor: each queued item is due one rising edge after it was driven
  always @(posedge clk) begin
    #2;
    if (rst_n && sbq.size() > 0) compare(sbq.pop_front());
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    item_t z;
    z.res = 8'h00; z.we = 1'b0; z.fl = 4'b0000; z.fwe = 4'b0000; z.tag = "R1 reset";
    repeat (3) @(posedge clk);
    #2;
    compare(z);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: idle and undefined codes
    drive(4'd0, 8'hFF, 3'd0, 1'b1, 1'b1, "R1 code0");
    drive(4'd12, 8'h5A, 3'd2, 1'b1, 1'b0, "R1 code12");
    drive(4'd15, 8'h81, 3'd7, 1'b0, 1'b1, "R1 code15");
    // R2: circular rotates
    drive(4'd1, 8'h85, 3'd0, 1'b0, 1'b0, "R2 rotl");
    drive(4'd1, 8'h00, 3'd0, 1'b1, 1'b0, "R2 R5 rotl zero");
    drive(4'd2, 8'h01, 3'd0, 1'b0, 1'b0, "R2 rotr");
    drive(4'd2, 8'h3C, 3'd0, 1'b1, 1'b0, "R2 rotr even");
    // R3: through carry
    drive(4'd3, 8'h80, 3'd0, 1'b0, 1'b0, "R3 rcl zero result");
    drive(4'd3, 8'h41, 3'd0, 1'b1, 1'b0, "R3 rcl carry in");
    drive(4'd4, 8'h01, 3'd0, 1'b0, 1'b0, "R3 rcr zero result");
    drive(4'd4, 8'h02, 3'd0, 1'b1, 1'b0, "R3 rcr carry in");
    // R4: shifts
    drive(4'd5, 8'hC1, 3'd0, 1'b1, 1'b0, "R4 sla");
    drive(4'd5, 8'h80, 3'd0, 1'b0, 1'b0, "R4 R5 sla zero");
    drive(4'd6, 8'h81, 3'd0, 1'b0, 1'b0, "R4 sra neg");
    drive(4'd6, 8'h01, 3'd0, 1'b1, 1'b0, "R4 sra zero");
    drive(4'd7, 8'hFF, 3'd0, 1'b1, 1'b0, "R4 srl");
    drive(4'd7, 8'h01, 3'd0, 1'b0, 1'b0, "R4 R5 srl zero");
    // R6: short forms clear z, accShort ignored elsewhere
    drive(4'd1, 8'h00, 3'd0, 1'b0, 1'b1, "R6 short rotl zero");
    drive(4'd2, 8'h01, 3'd0, 1'b0, 1'b1, "R6 short rotr");
    drive(4'd3, 8'h80, 3'd0, 1'b0, 1'b1, "R6 short rcl");
    drive(4'd4, 8'h01, 3'd0, 1'b0, 1'b1, "R6 short rcr");
    drive(4'd5, 8'h80, 3'd0, 1'b0, 1'b1, "R6 ignored sla");
    drive(4'd8, 8'h00, 3'd0, 1'b0, 1'b1, "R6 ignored swap");
    // R7: swap
    drive(4'd8, 8'hA5, 3'd0, 1'b1, 1'b0, "R7 swap");
    drive(4'd8, 8'h00, 3'd0, 1'b1, 1'b0, "R7 swap zero");
    // R8: bit test
    for (int i = 0; i < 8; i++) begin
      drive(4'd9, 8'h55, i[2:0], 1'b1, 1'b0, "R8 bit test");
    end
    drive(4'd9, 8'h80, 3'd7, 1'b0, 1'b1, "R8 bit7 set");
    // R9: set / reset
    drive(4'd10, 8'h00, 3'd0, 1'b1, 1'b0, "R9 set b0");
    drive(4'd10, 8'h00, 3'd7, 1'b1, 1'b0, "R9 set b7");
    drive(4'd10, 8'hFF, 3'd3, 1'b0, 1'b1, "R9 set already");
    drive(4'd11, 8'hFF, 3'd0, 1'b1, 1'b0, "R9 res b0");
    drive(4'd11, 8'hFF, 3'd7, 1'b0, 1'b0, "R9 res b7");
    drive(4'd11, 8'h10, 3'd4, 1'b1, 1'b0, "R9 res to zero");
    // R10: back-to-back latency
    drive(4'd1, 8'h01, 3'd0, 1'b0, 1'b0, "R10 seq a");
    drive(4'd9, 8'h01, 3'd0, 1'b1, 1'b0, "R10 seq b");
    drive(4'd0, 8'h01, 3'd0, 1'b1, 1'b0, "R10 seq c");
    @(negedge clk);
    opSel = 4'd0;
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule